// File: doc/BRIEF.md
# Board Interrupt Aggregator with Control Registers

This block gathers sixteen level-sensitive interrupt lines from board devices into one request line toward a host processor. Software chooses which lines may raise the request through an enable register. Whenever an enabled line changes level, a status register is overwritten with a one-hot code naming that line. The host request output then takes the new level of that line. The block holds a record of every line's current level. It updates this record on every change, whether the line is enabled or not. An enabled line can therefore report an event only when its level changes after the last recorded value.

Next to the interrupt logic sits a bank of ten plain 32-bit read/write registers for board control (LEDs, switches, slot control). The block gives them no meaning of their own. All registers are reached over a simple synchronous bus: a byte offset, a write strobe with 32-bit data, and a read strobe whose registered data appears one cycle later.

Top module: `irq_board_regs`

## Requirements
- R1: While rst_ni is low, every register, the level record, irq_o and rdata_o are zero, and they stay zero until written or until an input changes after release.
- R2: The level record follows irq_i on every clock, including masked lines. A line that changed while masked produces no event when it is enabled later, because its level then matches the record.
- R3: When a line n whose enable bit (bit n at offset 0xC0) is 1 differs from its recorded level, the status register (offset 0xD0) becomes exactly 1<<n at that clock edge.
- R4: At that edge, irq_o takes the new level of line n.
- R5: A change on a line whose enable bit is 0 leaves both the status register and irq_o unchanged.
- R6: When several enabled lines change on the same clock, the lowest-numbered one sets the status and irq_o. The other lines are recorded and raise no later event.
- R7: Writes to offsets 0xC0 and 0xD0 store the write data ANDed with 0x000FEEFF. Enable bits 8 and 12 therefore always read 0, and lines 8 and 12 can never cause an event.
- R8: Offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88, 0x90, 0xE0 and 0xE4 each store all 32 written bits and return them on read, independently of one another.
- R9: A read at any other offset, including offsets that are not word-aligned, returns zero. A write there changes no register.
- R10: rdata_o is updated at the clock edge where rd_i is high, with the value the register had before that edge. It holds its value while rd_i is low.
- R11: If an enabled event and a bus write to the status register fall on the same edge, the event's one-hot code is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Level-sensitive device interrupt lines |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Request line to the host |

## Verification
The interrupt path is tried with a single enabled line rising and falling, which shows whether the status overwrite and irq_o following are tied to the changing line. A second enabled line is raised while the first is still high, which separates overwrite from accumulation. Toggles on lines 8 and 12, and on a line whose enable was cleared, tell masked changes apart from enabled ones. Raising a masked line and enabling it afterwards shows that the level record advances regardless of the mask. Two lines rising together expose the priority order. A status write on the same edge as an event exposes the collision rule. A walk of write-then-read vectors over every scratch offset, the two interrupt registers, an unused word and a misaligned byte separates full-width storage, the 0xFEEFF write filter and zero return for unmapped reads.

// File: rtl/irqb_pkg.sv
package irqb_pkg;
  localparam logic [31:0] IRQ_KEEP = 32'h000F_EEFF;
  localparam logic [7:0]  OFS_MASK = 8'hC0;
  localparam logic [7:0]  OFS_STAT = 8'hD0;
  localparam int unsigned NUM_SCR  = 10;

  function automatic logic [7:0] scr_ofs(int unsigned i);
    case (i)
      0: return 8'h10;
      1: return 8'h14;
      2: return 8'h40;
      3: return 8'h60;
      4: return 8'h80;
      5: return 8'h84;
      6: return 8'h88;
      7: return 8'h90;
      8: return 8'hE0;
      default: return 8'hE4;
    endcase
  endfunction
endpackage

// File: rtl/irqb_level_track.sv
module irqb_level_track #(
  parameter int unsigned N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] irq_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] chg_o
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= irq_i;
  end

  assign lvl_o = lvl_q;
  assign chg_o = irq_i ^ lvl_q;
endmodule

// File: rtl/irqb_pick.sv
module irqb_pick #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] req_i,
  output logic         hit_o,
  output logic [N-1:0] onehot_o
);
  always_comb begin
    onehot_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) onehot_o = N'(1) << i;
    end
  end

  assign hit_o = |req_i;
endmodule

// File: rtl/irqb_irq_ctrl.sv
module irqb_irq_ctrl
  import irqb_pkg::*;
#(
  parameter int unsigned N      = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      chg_i,
  input  logic [N-1:0]      irq_i,
  input  logic              mask_we_i,
  input  logic              stat_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] stat_o,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] KEEP = DATA_W'(IRQ_KEEP);

  logic [DATA_W-1:0] mask_q, stat_q;
  logic              irq_q;
  logic [N-1:0]      en_chg, pick;
  logic              hit;

  assign en_chg = chg_i & mask_q[N-1:0];

  irqb_pick #(.N(N)) u_pick (
    .req_i   (en_chg),
    .hit_o   (hit),
    .onehot_o(pick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= wdata_i & KEEP;
      // an input event wins over a bus write in the same cycle
      if (hit) begin
        stat_q <= DATA_W'(pick);
        irq_q  <= |(pick & irq_i);
      end else if (stat_we_i) begin
        stat_q <= wdata_i & KEEP;
      end
    end
  end

  assign mask_o = mask_q;
  assign stat_o = stat_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/irqb_scratch_bank.sv
module irqb_scratch_bank
  import irqb_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NUM_SCR-1:0] sel;
  logic [DATA_W-1:0]  val [NUM_SCR];

  for (genvar g = 0; g < NUM_SCR; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(scr_ofs(g));
    logic [DATA_W-1:0] q;
    assign sel[g] = (addr_i == OFS);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            q <= '0;
      else if (wr_i && sel[g]) q <= wdata_i;
    end
    assign val[g] = q;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_SCR; i++) begin
      if (sel[i]) rdata_o = rdata_o | val[i];
    end
  end

  assign hit_o = |sel;
endmodule

// File: rtl/irq_board_regs.sv
module irq_board_regs
  import irqb_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 irq_o
);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

  logic [NUM_LINES-1:0] lvl_w, chg_w;
  logic [DATA_W-1:0]    mask_w, stat_w, scr_rdata, rd_next, rdata_q;
  logic                 scr_hit;

  irqb_level_track #(.N(NUM_LINES)) u_lvl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .irq_i (irq_i),
    .lvl_o (lvl_w),
    .chg_o (chg_w)
  );

  irqb_irq_ctrl #(.N(NUM_LINES), .DATA_W(DATA_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .chg_i    (chg_w),
    .irq_i    (irq_i),
    .mask_we_i(wr_i && (addr_i == A_MASK)),
    .stat_we_i(wr_i && (addr_i == A_STAT)),
    .wdata_i  (wdata_i),
    .mask_o   (mask_w),
    .stat_o   (stat_w),
    .irq_o    (irq_o)
  );

  irqb_scratch_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_scr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .hit_o  (scr_hit),
    .rdata_o(scr_rdata)
  );

  always_comb begin
    rd_next = '0;
    if (scr_hit)                rd_next = scr_rdata;
    else if (addr_i == A_MASK)  rd_next = mask_w;
    else if (addr_i == A_STAT)  rd_next = stat_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irqb_chk.sv
module irqb_chk
  import irqb_pkg::*;
#(
  parameter int unsigned N      = 16,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N-1:0]      irq_i,
  input logic [N-1:0]      lvl,
  input logic [DATA_W-1:0] mask,
  input logic [DATA_W-1:0] stat,
  input logic              irq_o,
  input logic              wr_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o
);
  logic [N-1:0] en_chg;
  logic         stat_wr, mask_wr, mapped;

  assign en_chg  = (irq_i ^ lvl) & mask[N-1:0];
  assign stat_wr = wr_i && (addr_i == ADDR_W'(OFS_STAT));
  assign mask_wr = wr_i && (addr_i == ADDR_W'(OFS_MASK));

  always_comb begin
    mapped = (addr_i == ADDR_W'(OFS_MASK)) || (addr_i == ADDR_W'(OFS_STAT));
    for (int i = 0; i < NUM_SCR; i++) begin
      if (addr_i == ADDR_W'(scr_ofs(i))) mapped = 1'b1;
    end
  end

  // R2
  level_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> lvl == $past(irq_i));

  // R3
  stat_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |en_chg |=> $onehot(stat));

  // R4
  parent_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |en_chg |=> irq_o == |($past(irq_i) & stat[N-1:0]));

  // R5
  masked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(|en_chg) && !stat_wr) |=> ($stable(stat) && $stable(irq_o)));

  // R7
  keep_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr |=> mask == ($past(wdata_i) & DATA_W'(IRQ_KEEP)));

  // R9
  unmapped_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !mapped) |=> rdata_o == '0);

  // R10
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

bind irq_board_regs irqb_chk #(.N(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .irq_i  (irq_i),
  .lvl    (lvl_w),
  .mask   (mask_w),
  .stat   (stat_w),
  .irq_o  (irq_o),
  .wr_i   (wr_i),
  .rd_i   (rd_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o)
);

// File: tb/sim_irq_board_regs.sv
`timescale 1ns/1ps
module sim_irq_board_regs;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] irq = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  irq_board_regs u0 (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .wr_i(wr), .rd_i(rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [7:0]  ofs;
    logic [31:0] wv;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'h10, 32'hA5A5_0001, 32'hA5A5_0001},
    '{8'h14, 32'h5A5A_0002, 32'h5A5A_0002},
    '{8'h40, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{8'h60, 32'h1234_5678, 32'h1234_5678},
    '{8'h80, 32'h8000_0001, 32'h8000_0001},
    '{8'h84, 32'h0F0F_F0F0, 32'h0F0F_F0F0},
    '{8'h88, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    '{8'h90, 32'hCAFE_0090, 32'hCAFE_0090},
    '{8'hE0, 32'h0000_00E0, 32'h0000_00E0},
    '{8'hE4, 32'h7654_3210, 32'h7654_3210},
    '{8'hC0, 32'hFFFF_FFFF, 32'h000F_EEFF},
    '{8'hD0, 32'hFFFF_FFFF, 32'h000F_EEFF},
    '{8'h20, 32'hFFFF_FFFF, 32'h0000_0000},
    '{8'h12, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic set_irq(logic [15:0] v);
    @(negedge clk); irq = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_stat(string tag, logic [31:0] exp);
    logic [31:0] d;
    bus_rd(8'hD0, d);
    check(tag, d, exp);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 irq_o in reset", {31'd0, irq_o}, 32'd0);
    check("R1 rdata in reset", rdata, 32'd0);
    rst_ni = 1'b1;
    bus_rd(8'hC0, d); check("R1 mask after reset", d, 32'd0);
    bus_rd(8'hD0, d); check("R1 status after reset", d, 32'd0);
    bus_rd(8'h88, d); check("R1 scratch after reset", d, 32'd0);

    // table: write everything, then read everything back
    for (int i = 0; i < NV; i++) bus_wr(VECS[i].ofs, VECS[i].wv);
    for (int i = 0; i < NV; i++) begin
      bus_rd(VECS[i].ofs, d);
      check($sformatf("R8/R7/R9 table ofs %h", VECS[i].ofs), d, VECS[i].exp);
    end

    // R10: read latency and hold
    bus_rd(8'h88, d); check("R10 read value", d, 32'hDEAD_BEEF);
    @(negedge clk); addr = 8'h10;
    repeat (3) @(negedge clk);
    check("R10 hold without strobe", rdata, 32'hDEAD_BEEF);

    bus_wr(8'hC0, 32'h0000_FFFF);
    // R3 R4 single line
    set_irq(16'h0008); check("R4 line3 rise", {31'd0, irq_o}, 32'd1);
    check_stat("R3 line3 code", 32'h8);
    set_irq(16'h0000); check("R4 line3 fall", {31'd0, irq_o}, 32'd0);
    check_stat("R3 line3 code kept", 32'h8);
    // R3 overwrite, not accumulate
    set_irq(16'h0020); check("R4 line5 rise", {31'd0, irq_o}, 32'd1);
    check_stat("R3 line5 code", 32'h20);
    set_irq(16'h0220); check("R4 line9 rise", {31'd0, irq_o}, 32'd1);
    check_stat("R3 overwrite by line9", 32'h200);
    set_irq(16'h0200); check("R4 line5 fall", {31'd0, irq_o}, 32'd0);
    check_stat("R3 overwrite by line5", 32'h20);
    set_irq(16'h0000); check_stat("R3 line9 fall", 32'h200);
    // R5 R7: lines 8 and 12 cannot be enabled
    set_irq(16'h0004); check("R4 line2 rise", {31'd0, irq_o}, 32'd1);
    set_irq(16'h0104); check("R7 line8 masked irq", {31'd0, irq_o}, 32'd1);
    check_stat("R5 line8 masked status", 32'h4);
    set_irq(16'h1104); check_stat("R7 line12 masked status", 32'h4);
    set_irq(16'h0004); check("R5 masked falls irq", {31'd0, irq_o}, 32'd1);
    check_stat("R5 masked falls status", 32'h4);
    set_irq(16'h0000); check("R4 line2 fall", {31'd0, irq_o}, 32'd0);
    // R2: masked change updates the record
    bus_wr(8'hC0, 32'h0);
    set_irq(16'h0080); check("R5 line7 masked irq", {31'd0, irq_o}, 32'd0);
    bus_wr(8'hC0, 32'h80);
    repeat (2) @(negedge clk);
    check("R2 no late event irq", {31'd0, irq_o}, 32'd0);
    check_stat("R2 no late event status", 32'h4);
    set_irq(16'h0000); check_stat("R2 line7 fall event", 32'h80);
    set_irq(16'h0080); check("R2 line7 rise irq", {31'd0, irq_o}, 32'd1);
    set_irq(16'h0000); check("R2 line7 fall irq", {31'd0, irq_o}, 32'd0);
    // R6 priority
    bus_wr(8'hC0, 32'h0000_FFFF);
    set_irq(16'h0410); check("R6 pair rise irq", {31'd0, irq_o}, 32'd1);
    check_stat("R6 lowest wins", 32'h10);
    check_stat("R6 no second event", 32'h10);
    set_irq(16'h0400); check("R6 line4 fall irq", {31'd0, irq_o}, 32'd0);
    check_stat("R6 line4 fall code", 32'h10);
    set_irq(16'h0000); check_stat("R6 line10 fall code", 32'h400);
    // R11 collision
    @(negedge clk); irq = 16'h0002; wr = 1'b1; addr = 8'hD0; wdata = 32'h0000_FFFF;
    @(posedge clk);
    @(negedge clk); wr = 1'b0;
    check("R11 irq on collision", {31'd0, irq_o}, 32'd1);
    check_stat("R11 event wins", 32'h2);
    bus_wr(8'hD0, 32'h0000_1234);
    check_stat("R7 status write filtered", 32'h0234);
    check("R5 status write leaves irq", {31'd0, irq_o}, 32'd1);
    set_irq(16'h0000); check("R4 line1 fall", {31'd0, irq_o}, 32'd0);
    // R9 unmapped write
    bus_wr(8'h24, 32'h5555_5555);
    bus_rd(8'h24, d); check("R9 unmapped read", d, 32'd0);
    bus_rd(8'h10, d); check("R9 neighbours untouched", d, 32'hA5A5_0001);
    // R1 reset again
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    bus_rd(8'h10, d); check("R1 scratch cleared", d, 32'd0);
    bus_rd(8'hC0, d); check("R1 mask cleared", d, 32'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule